// File: doc/BRIEF.md
# Address-Aligned Completion Packer

This block assembles one completion at a time onto an AXI4-Stream master port. The byte positions of the payload follow the data address. A completion is announced by a header handshake. The header carries a 12-byte descriptor, a flag that marks a memory-read completion, and the low bits of the starting byte address. The payload then arrives on a separate input stream, packed densely from lane 0. A byte count on the final beat gives the number of valid bytes in that beat.

The descriptor always leads the packet and fills its own beats. The payload starts on a fresh beat. For a memory-read completion, the first payload byte is placed on the lane given by the starting address modulo the beat width in bytes. For any other completion, it is placed on lane 0.

A holding register and a byte-granular rotator carry bytes that spill over a beat boundary into the next beat. When the shifted payload overruns the last input beat, the block emits one extra closing beat. Unused lanes are driven as zero. `tkeep` marks Dwords that hold at least one payload or descriptor byte.

Top module: `cpl_addr_pack`

## Requirements
- R1: `hdr_ready` is high only while no packet is in progress. While `m_tvalid` is high, `hdr_ready` is low. The beat after a header handshake is a descriptor beat with `m_tlast` low.
- R2: The descriptor takes ceil(12/B) beats, where B = DATA_W/8. Descriptor byte i (bits [8i+7:8i] of `hdr_desc`) sits in descriptor beat i/B on lane i%B. Lanes past byte 11 are zero. `tkeep` bit d is set when Dword d of the beat holds a descriptor byte; with DATA_W=64 this gives 2'b11 and then 2'b01.
- R3: The payload begins in the beat after the last descriptor beat. `pl_ready` is low in every descriptor beat, so no payload byte shares a beat with the descriptor.
- R4: For a memory-read completion (`hdr_is_mrd`=1), payload byte 0 goes on lane `hdr_addr` mod B of the first payload beat.
- R5: For any other completion (`hdr_is_mrd`=0), payload byte 0 goes on lane 0 whatever the address.
- R6: With start lane s, payload byte k appears in payload beat (s+k)/B on lane (s+k)%B. No byte is lost or reordered across beat boundaries.
- R7: In payload beats, lanes below the start lane and lanes past the final byte are zero, even when the input carries other values beyond `pl_nbytes`. `tkeep` bit d is set exactly when Dword d holds at least one payload byte.
- R8: `m_tlast` is set only on the beat that holds the final payload byte. When s + (bytes of the last input beat) exceeds B, one extra beat follows the last input beat. After the `m_tlast` beat the block is idle again.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tkeep` and `m_tlast` hold their values, provided the payload source also holds.
- R10: In reset, `m_tvalid` is low and `hdr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header accepted (idle) |
| hdr_desc | input | 96 | Descriptor, byte i at bits [8i+7:8i] |
| hdr_is_mrd | input | 1 | 1 = memory-read completion |
| hdr_addr | input | ADDR_W | Low bits of starting byte address |
| pl_valid | input | 1 | Payload beat offered |
| pl_ready | output | 1 | Payload beat accepted |
| pl_data | input | DATA_W | Payload bytes, dense from lane 0 |
| pl_last | input | 1 | Final payload beat |
| pl_nbytes | input | log2(DATA_W/8)+1 | Valid bytes in final beat (1..B) |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat accepted |
| m_tdata | output | DATA_W | Output beat data |
| m_tkeep | output | DATA_W/32 | Dword-granular byte-valid mask |
| m_tlast | output | 1 | Final beat of the packet |

## Verification
The bench pushes start lanes at 0, B-1 and in between, together with lengths that end exactly on a beat edge, end one byte short of it, or spill one byte past it. A rotator with an off-by-one selection would move every byte one lane. A wrong closing-beat decision would drop the spilled bytes, or would emit an empty trailing beat with `tlast` in the wrong place. Non-memory-read completions with nonzero address bits catch a design that applies the address offset to every completion. Input bytes beyond `pl_nbytes` are filled with a nonzero pattern, so a missing null mask shows up as stray data in the closing lanes. Random back-pressure checks that a stalled beat does not change, in particular while a beat is being assembled from the holding register.

// File: rtl/cpl_addr_pack_pkg.sv
`timescale 1ns/1ps
package cpl_addr_pack_pkg;

   localparam int DESC_BYTES = 12;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DESC  = 2'd1,
      ST_PAY   = 2'd2,
      ST_FLUSH = 2'd3
   } pack_state_e;

   function automatic int desc_beats(input int beat_bytes);
      return (DESC_BYTES + beat_bytes - 1) / beat_bytes;
   endfunction

endpackage

// File: rtl/cpl_addr_pack_desc_slice.sv
`timescale 1ns/1ps
module cpl_addr_pack_desc_slice
   import cpl_addr_pack_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 1
) (
   input  logic [DESC_BYTES*8-1:0] desc,
   input  logic [IDX_W-1:0]        idx,
   output logic [DATA_W-1:0]       beat
);
   localparam int BYTES = DATA_W / 8;
   localparam int NB    = desc_beats(BYTES);
   localparam int PAD_W = NB * DATA_W;

   if (NB == 1) begin : g_single
      logic unused_idx;
      assign unused_idx = ^idx;
      assign beat = {{(DATA_W - DESC_BYTES*8){1'b0}}, desc};
   end else begin : g_multi
      logic [PAD_W-1:0] pad;
      assign pad  = {{(PAD_W - DESC_BYTES*8){1'b0}}, desc};
      assign beat = pad[idx*DATA_W +: DATA_W];
   end

endmodule

// File: rtl/cpl_addr_pack_shift.sv
`timescale 1ns/1ps
module cpl_addr_pack_shift #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 3
) (
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] hold,
   input  logic [LANE_W-1:0] off,
   output logic [DATA_W-1:0] beat
);
   localparam int BYTES = DATA_W / 8;

   logic [2*DATA_W-1:0] cat;

   always_comb begin
      cat = {cur, hold};
      for (int j = 0; j < BYTES; j++) begin
         beat[j*8 +: 8] = cat[(j + BYTES - int'(off))*8 +: 8];
      end
   end

endmodule

// File: rtl/cpl_addr_pack_keep.sv
`timescale 1ns/1ps
module cpl_addr_pack_keep #(
   parameter int DATA_W = 64,
   parameter int END_W  = 5
) (
   input  logic [END_W-1:0]      lo,
   input  logic [END_W-1:0]      hi,
   output logic [DATA_W/32-1:0]  keep
);
   localparam int KEEP_W = DATA_W / 32;

   for (genvar d = 0; d < KEEP_W; d++) begin : g_dw
      localparam logic [END_W-1:0] DW_LO = END_W'(d*4);
      localparam logic [END_W-1:0] DW_HI = END_W'(d*4 + 4);
      assign keep[d] = (lo < DW_HI) && (hi > DW_LO);
   end

endmodule

// File: rtl/cpl_addr_pack.sv
`timescale 1ns/1ps
module cpl_addr_pack
   import cpl_addr_pack_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 7
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         hdr_valid,
   output logic                         hdr_ready,
   input  logic [DESC_BYTES*8-1:0]      hdr_desc,
   input  logic                         hdr_is_mrd,
   input  logic [ADDR_W-1:0]            hdr_addr,
   input  logic                         pl_valid,
   output logic                         pl_ready,
   input  logic [DATA_W-1:0]            pl_data,
   input  logic                         pl_last,
   input  logic [$clog2(DATA_W/8):0]    pl_nbytes,
   output logic                         m_tvalid,
   input  logic                         m_tready,
   output logic [DATA_W-1:0]            m_tdata,
   output logic [DATA_W/32-1:0]         m_tkeep,
   output logic                         m_tlast
);
   localparam int BYTES     = DATA_W / 8;
   localparam int LANE_W    = $clog2(BYTES);
   localparam int CNT_W     = LANE_W + 1;
   localparam int END_W     = LANE_W + 2;
   localparam int DESC_NB   = desc_beats(BYTES);
   localparam int IDX_W     = (DESC_NB > 1) ? $clog2(DESC_NB) : 1;
   localparam int LAST_DESC = DESC_BYTES - (DESC_NB - 1) * BYTES;

   if (DATA_W != 64 && DATA_W != 128 && DATA_W != 256) begin : g_bad_width
      $error("cpl_addr_pack: DATA_W must be 64, 128 or 256");
   end
   if (ADDR_W < LANE_W) begin : g_bad_addr
      $error("cpl_addr_pack: ADDR_W too narrow for lane offset");
   end

   pack_state_e              state_q;
   logic [IDX_W-1:0]         beat_idx_q;
   logic [DESC_BYTES*8-1:0]  desc_q;
   logic [LANE_W-1:0]        off_q;
   logic [DATA_W-1:0]        hold_q;
   logic                     first_q;
   logic [END_W-1:0]         rem_q;

   logic [DATA_W-1:0]        pl_masked;
   logic [DATA_W-1:0]        shift_cur;
   logic [DATA_W-1:0]        shift_beat;
   logic [DATA_W-1:0]        desc_beat;
   logic [END_W-1:0]         end_sum;
   logic                     fits;
   logic [END_W-1:0]         keep_lo;
   logic [END_W-1:0]         keep_hi;
   logic [DATA_W/32-1:0]     keep_vec;
   logic                     desc_last_beat;
   logic                     unused_addr;

   assign unused_addr    = ^hdr_addr;
   assign end_sum        = END_W'(off_q) + END_W'(pl_nbytes);
   assign fits           = (end_sum <= END_W'(BYTES));
   assign desc_last_beat = (beat_idx_q == IDX_W'(DESC_NB - 1));

   always_comb begin
      for (int l = 0; l < BYTES; l++) begin
         pl_masked[l*8 +: 8] = (!pl_last || (CNT_W'(l) < pl_nbytes)) ?
                               pl_data[l*8 +: 8] : 8'h00;
      end
   end

   assign shift_cur = (state_q == ST_FLUSH) ? '0 : pl_masked;

   cpl_addr_pack_desc_slice #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_desc (
      .desc (desc_q),
      .idx  (beat_idx_q),
      .beat (desc_beat)
   );

   cpl_addr_pack_shift #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W)
   ) u_shift (
      .cur  (shift_cur),
      .hold (hold_q),
      .off  (off_q),
      .beat (shift_beat)
   );

   cpl_addr_pack_keep #(
      .DATA_W (DATA_W),
      .END_W  (END_W)
   ) u_keep (
      .lo   (keep_lo),
      .hi   (keep_hi),
      .keep (keep_vec)
   );

   always_comb begin
      hdr_ready = 1'b0;
      pl_ready  = 1'b0;
      m_tvalid  = 1'b0;
      m_tdata   = '0;
      m_tlast   = 1'b0;
      keep_lo   = '0;
      keep_hi   = '0;
      unique case (state_q)
         ST_IDLE: begin
            hdr_ready = 1'b1;
         end
         ST_DESC: begin
            m_tvalid = 1'b1;
            m_tdata  = desc_beat;
            keep_hi  = desc_last_beat ? END_W'(LAST_DESC) : END_W'(BYTES);
         end
         ST_PAY: begin
            m_tvalid = pl_valid;
            pl_ready = m_tready;
            m_tdata  = shift_beat;
            m_tlast  = pl_last && fits;
            keep_lo  = first_q ? END_W'(off_q) : '0;
            keep_hi  = (pl_last && fits) ? end_sum : END_W'(BYTES);
         end
         ST_FLUSH: begin
            m_tvalid = 1'b1;
            m_tdata  = shift_beat;
            m_tlast  = 1'b1;
            keep_hi  = rem_q;
         end
         default: ;
      endcase
   end

   assign m_tkeep = keep_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         beat_idx_q <= '0;
         desc_q     <= '0;
         off_q      <= '0;
         hold_q     <= '0;
         first_q    <= 1'b0;
         rem_q      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (hdr_valid) begin
                  desc_q     <= hdr_desc;
                  off_q      <= hdr_is_mrd ? hdr_addr[LANE_W-1:0] : '0;
                  beat_idx_q <= '0;
                  state_q    <= ST_DESC;
               end
            end
            ST_DESC: begin
               if (m_tready) begin
                  if (desc_last_beat) begin
                     hold_q  <= '0;
                     first_q <= 1'b1;
                     state_q <= ST_PAY;
                  end else begin
                     beat_idx_q <= beat_idx_q + 1'b1;
                  end
               end
            end
            ST_PAY: begin
               if (pl_valid && m_tready) begin
                  hold_q  <= pl_masked;
                  first_q <= 1'b0;
                  if (pl_last) begin
                     if (fits) begin
                        state_q <= ST_IDLE;
                     end else begin
                        rem_q   <= end_sum - END_W'(BYTES);
                        state_q <= ST_FLUSH;
                     end
                  end
               end
            end
            ST_FLUSH: begin
               if (m_tready) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cpl_addr_pack_chk.sv
`timescale 1ns/1ps
module cpl_addr_pack_chk #(
   parameter int DATA_W = 64
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  hdr_valid,
   input logic                  hdr_ready,
   input logic                  pl_ready,
   input logic                  m_tvalid,
   input logic                  m_tready,
   input logic [DATA_W-1:0]     m_tdata,
   input logic [DATA_W/32-1:0]  m_tkeep,
   input logic                  m_tlast
);

   // R1: a header handshake is followed by a non-final descriptor beat
   p_desc_follows_hdr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_ready |=> m_tvalid && !m_tlast && !hdr_ready);

   // R1: no new header is taken while a beat is offered
   p_busy_blocks_hdr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> !hdr_ready);

   // R3: payload input is closed in the first descriptor beat
   p_no_payload_in_desc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_ready |=> !pl_ready);

   // R7: every offered beat carries at least one valid Dword
   p_keep_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> (m_tkeep != '0));

   // R8: the final beat returns the block to idle
   p_last_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && m_tready && m_tlast |=> hdr_ready);

   // R9: a stalled beat stays unchanged
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata)
                                && $stable(m_tkeep) && $stable(m_tlast));

endmodule

bind cpl_addr_pack cpl_addr_pack_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hdr_valid (hdr_valid),
   .hdr_ready (hdr_ready),
   .pl_ready  (pl_ready),
   .m_tvalid  (m_tvalid),
   .m_tready  (m_tready),
   .m_tdata   (m_tdata),
   .m_tkeep   (m_tkeep),
   .m_tlast   (m_tlast)
);

// File: tb/cpl_addr_pack_tb.sv
`timescale 1ns/1ps
module cpl_addr_pack_tb_top;
   localparam int DATA_W = 64;
   localparam int ADDR_W = 7;
   localparam int BYTES  = DATA_W / 8;
   localparam int KEEP_W = DATA_W / 32;
   localparam int CNT_W  = $clog2(BYTES) + 1;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                hdr_valid = 1'b0;
   logic                hdr_ready;
   logic [95:0]         hdr_desc = '0;
   logic                hdr_is_mrd = 1'b0;
   logic [ADDR_W-1:0]   hdr_addr = '0;
   logic                pl_valid = 1'b0;
   logic                pl_ready;
   logic [DATA_W-1:0]   pl_data = '0;
   logic                pl_last = 1'b0;
   logic [CNT_W-1:0]    pl_nbytes = '0;
   logic                m_tvalid;
   logic                m_tready = 1'b1;
   logic [DATA_W-1:0]   m_tdata;
   logic [KEEP_W-1:0]   m_tkeep;
   logic                m_tlast;

   always #2 clk = ~clk;

   cpl_addr_pack #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_desc(hdr_desc),
      .hdr_is_mrd(hdr_is_mrd), .hdr_addr(hdr_addr),
      .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
      .pl_last(pl_last), .pl_nbytes(pl_nbytes),
      .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
      .m_tkeep(m_tkeep), .m_tlast(m_tlast)
   );

   int n_chk = 0;
   int n_fail = 0;

   logic [DATA_W-1:0] exp_data[$];
   logic [KEEP_W-1:0] exp_keep[$];
   logic              exp_last[$];
   string             exp_tag[$];
   logic [7:0]        cur_pay[$];

   function automatic void chk(input bit ok, input string req, input string what,
                               input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endfunction

   // reference: expected beats of one completion
   function automatic void model_push(input logic [95:0] d, input bit mrd,
                                      input logic [ADDR_W-1:0] a, input int len);
      int nbd, off, tot, nbt;
      logic [DATA_W-1:0] bd;
      logic [KEEP_W-1:0] bk;
      nbd = (12 + BYTES - 1) / BYTES;
      for (int b = 0; b < nbd; b++) begin
         bd = '0; bk = '0;
         for (int l = 0; l < BYTES; l++)
            if (b*BYTES + l < 12) bd[l*8 +: 8] = d[(b*BYTES + l)*8 +: 8];
         for (int k = 0; k < KEEP_W; k++)
            if (b*BYTES + k*4 < 12) bk[k] = 1'b1;
         exp_data.push_back(bd); exp_keep.push_back(bk);
         exp_last.push_back(1'b0); exp_tag.push_back("R2");
      end
      off = mrd ? (int'(a) % BYTES) : 0;
      tot = off + len;
      nbt = (tot + BYTES - 1) / BYTES;
      for (int b = 0; b < nbt; b++) begin
         bd = '0; bk = '0;
         for (int l = 0; l < BYTES; l++) begin
            int g;
            g = b*BYTES + l;
            if (g >= off && g < tot) begin
               bd[l*8 +: 8] = cur_pay[g - off];
               bk[l/4] = 1'b1;
            end
         end
         exp_data.push_back(bd); exp_keep.push_back(bk);
         exp_last.push_back(b == nbt - 1);
         if (b == 0)            exp_tag.push_back(mrd ? "R4" : "R5");
         else if (b == nbt - 1) exp_tag.push_back("R8");
         else                   exp_tag.push_back("R6");
      end
   endfunction

   task automatic send_cpl(input bit mrd, input logic [ADDR_W-1:0] a,
                           input int len, input int seed);
      logic [95:0] d;
      int nin;
      bit ok;
      for (int i = 0; i < 12; i++) d[i*8 +: 8] = 8'(i*17 + seed*5 + 1);
      cur_pay.delete();
      for (int k = 0; k < len; k++) cur_pay.push_back(8'((seed*13 + k*29) % 255 + 1));
      model_push(d, mrd, a, len);
      @(negedge clk);
      hdr_valid = 1'b1; hdr_desc = d; hdr_is_mrd = mrd; hdr_addr = a;
      ok = 1'b0;
      while (!ok) begin
         #1 ok = hdr_ready;
         @(negedge clk);
      end
      hdr_valid = 1'b0;
      nin = (len + BYTES - 1) / BYTES;
      for (int i = 0; i < nin; i++) begin
         if ((seed + i) % 3 == 0) begin
            pl_valid = 1'b0;
            @(negedge clk);
         end
         pl_valid = 1'b1;
         pl_last  = (i == nin - 1);
         pl_nbytes = (i == nin - 1) ? CNT_W'(len - (nin - 1)*BYTES) : '0;
         for (int l = 0; l < BYTES; l++)
            pl_data[l*8 +: 8] = (i*BYTES + l < len) ? cur_pay[i*BYTES + l] : 8'hEE;
         ok = 1'b0;
         while (!ok) begin
            #1 ok = pl_ready;
            @(negedge clk);
         end
      end
      pl_valid = 1'b0; pl_last = 1'b0;
   endtask

   // back-pressure source
   bit        stall_mode = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_tready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
   end

   // monitor, compared every clock
   bit                prev_stall = 1'b0;
   logic [DATA_W-1:0] prev_data;
   logic [KEEP_W-1:0] prev_keep;
   logic              prev_last;
   always begin
      @(negedge clk);
      #1;
      if (rst_n) begin
         if (m_tvalid) begin
            chk(hdr_ready == 1'b0, "R1", "hdr_ready while busy", DATA_W'(hdr_ready), '0);
            if (prev_stall) begin
               chk(m_tdata == prev_data, "R9", "stalled tdata", m_tdata, prev_data);
               chk({m_tkeep, m_tlast} == {prev_keep, prev_last}, "R9", "stalled keep/last",
                   DATA_W'({m_tkeep, m_tlast}), DATA_W'({prev_keep, prev_last}));
            end
            if (m_tready) begin
               if (exp_data.size() == 0) begin
                  chk(1'b0, "R8", "unexpected beat", m_tdata, '0);
               end else begin
                  string t;
                  logic [DATA_W-1:0] ed;
                  logic [KEEP_W-1:0] ek;
                  logic el;
                  t = exp_tag.pop_front(); ed = exp_data.pop_front();
                  ek = exp_keep.pop_front(); el = exp_last.pop_front();
                  chk(m_tdata == ed, t, "tdata", m_tdata, ed);
                  chk(m_tkeep == ek, "R7", "tkeep", DATA_W'(m_tkeep), DATA_W'(ek));
                  chk(m_tlast == el, "R8", "tlast", DATA_W'(m_tlast), DATA_W'(el));
                  if (t == "R2")
                     chk(pl_ready == 1'b0, "R3", "pl_ready in descriptor beat",
                         DATA_W'(pl_ready), '0);
               end
            end
         end
         prev_stall = m_tvalid && !m_tready;
         prev_data = m_tdata; prev_keep = m_tkeep; prev_last = m_tlast;
      end
   end

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(m_tvalid == 1'b0, "R10", "tvalid in reset", DATA_W'(m_tvalid), '0);
      chk(hdr_ready == 1'b1, "R10", "hdr_ready in reset", DATA_W'(hdr_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;
      // directed corners, full throughput
      send_cpl(1'b0, 7'h45, 13, 1);   // R5: address ignored, lane 0
      send_cpl(1'b1, 7'h00, 8,  2);   // R4: lane 0, exact beat
      send_cpl(1'b1, 7'h03, 5,  3);   // R4/R8: ends exactly on beat edge
      send_cpl(1'b1, 7'h07, 2,  4);   // R8: spill of one byte
      send_cpl(1'b1, 7'h41, 30, 5);   // R6: long, offset 1
      send_cpl(1'b1, 7'h06, 1,  6);   // R7: single byte in high lane
      send_cpl(1'b1, 7'h0C, 16, 7);   // R8: closing beat after full input
      send_cpl(1'b0, 7'h7F, 1,  8);   // R5: single byte, lane 0
      send_cpl(1'b1, 7'h7F, 9,  9);   // R6: offset B-1
      // mixed patterns with back-pressure
      stall_mode = 1'b1;
      for (int t = 0; t < 30; t++)
         send_cpl((t % 3) != 0, ADDR_W'((t*23) % 128), 1 + (t*11) % 40, 10 + t);
      for (int w = 0; w < 2000 && exp_data.size() != 0; w++) @(negedge clk);
      repeat (4) @(negedge clk);
      #1;
      chk(exp_data.size() == 0, "R8", "beats outstanding", DATA_W'(exp_data.size()), '0);
      chk(hdr_ready == 1'b1, "R8", "idle after last", DATA_W'(hdr_ready), 1);
      finish_run();
   end

endmodule